// File: doc/BRIEF.md
# Indexed Address Timing Sequencer

This block produces the effective address and the exact sequence of bus cycles for the indexed memory operand of an 8-bit processor. It handles three modes: absolute plus X, absolute plus Y, and zero-page pointer plus Y. For the pointer mode, the two pointer bytes are read from page zero. For each operation class (read, write, read-modify-write) it issues one bus cycle per clock. Each cycle carries an address, a write flag, write data and a tag that names the kind of cycle.

Decode logic starts an operand phase with a one-cycle `start`. At that point it supplies the mode, the operation class, both index registers and the two operand bytes. From then on the block owns the bus until its `done` cycle. A memory model answers reads on `rd_data` in the same cycle.

An indexing penalty cycle reads from the address with the high byte left uncorrected. A read pays this penalty only when the low-byte addition carries. A write or a read-modify-write pays it every time. A read-modify-write also writes the unmodified value back in a dead cycle before the real write.

Top module: `ixs_seq`

## Requirements
- R1: After reset, and whenever no operation is in progress, `bus_valid`, `bus_we` and `done` are 0 and `cyc_type` is 0 (none).
- R2: A read (op 0, or the unused code 3) in an absolute mode whose low-byte sum does not carry uses exactly one bus cycle. That cycle is tagged read (3), at address {hi, lo+index}, and starts on the clock after `start` is taken.
- R3: A read whose low-byte sum carries first issues a penalty cycle (tag 2) at {hi, (lo+index) mod 256}. It then issues the read at {(hi+1) mod 256, (lo+index) mod 256}.
- R4: Mode 0 (and unused mode 3) indexes with `x_idx`. Mode 1 indexes with `y_idx`. Mode 2 uses `oper_lo` as a page-zero pointer and indexes with `y_idx`.
- R5: A write (op 1) always issues the penalty cycle, carry or not. It then issues one write cycle (tag 4, `bus_we`=1, `bus_wdata`=`wr_data`) at the corrected address.
- R6: A read-modify-write (op 2) issues, in order: the penalty cycle, a read (tag 3), a dummy write (tag 5) of the byte just read, and a final write (tag 4) of `wr_data`. The last three cycles use the corrected address.
- R7: In mode 2, two pointer reads (tag 1) come first: at {0, ptr} and at {0, (ptr+1) mod 256}. Their bytes form the base address (low byte from the first read), and the rules of R2–R6 then apply.
- R8: `done` is high for exactly the last bus cycle of each operation, and `bus_valid` is high from the first to the last cycle. A `start` seen while an operation runs is ignored, as are changes to the other request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand phase (taken only when idle) |
| mode | input | 2 | 0 abs+X, 1 abs+Y, 2 page-zero pointer+Y, 3 as 0 |
| op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 as read |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| oper_lo | input | 8 | Operand low byte, or pointer in mode 2 |
| oper_hi | input | 8 | Operand high byte (unused in mode 2) |
| rd_data | input | 8 | Byte returned for the current bus address |
| wr_data | input | 8 | Value stored by the final write cycle |
| done | output | 1 | Last bus cycle of the operation |
| bus_valid | output | 1 | A bus cycle is issued this clock |
| bus_addr | output | 16 | Bus address |
| bus_we | output | 1 | Bus cycle is a write |
| bus_wdata | output | 8 | Data for write cycles, 0 otherwise |
| cyc_type | output | 3 | 0 none, 1 pointer, 2 penalty, 3 read, 4 write, 5 dummy write |

## Verification
Reads are tried with low bytes and indexes that sum below 256 and with sums that carry. Some carrying sums use a high byte of 0xFF, so the corrected high byte wraps to zero. These cases separate the one-cycle path from the penalty path. The same address pairs are used with writes and read-modify-writes to show the penalty does not depend on the carry there. Pointers of 0xFF check the page-zero wrap of the second pointer read. Stray `start` pulses with changed request inputs during a running operation show that the captured request cannot be disturbed. Several hundred seeded random requests mix all modes and classes.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

    typedef enum logic [2:0] {
        CT_NONE  = 3'd0,
        CT_PTR   = 3'd1,
        CT_FIX   = 3'd2,
        CT_READ  = 3'd3,
        CT_WRITE = 3'd4,
        CT_DUMMY = 3'd5
    } ctype_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLO,
        ST_PHI,
        ST_FIX,
        ST_RD,
        ST_DWR,
        ST_WR
    } seq_st_e;

    localparam logic [1:0] MODE_ABSX = 2'd0;
    localparam logic [1:0] MODE_ABSY = 2'd1;
    localparam logic [1:0] MODE_ZPY  = 2'd2;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_RMW   = 2'd2;

endpackage

// File: rtl/ixs_addr_calc.sv
module ixs_addr_calc #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] base_lo,
    input  logic [BYTE_W-1:0] base_hi,
    input  logic [BYTE_W-1:0] index,
    input  logic              read_only,
    output logic [BYTE_W-1:0] sum_lo,
    output logic [BYTE_W-1:0] hi_fixed,
    output logic              pay_fix
);
    logic [BYTE_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, base_lo} + {1'b0, index};
        sum_lo   = wide_sum[BYTE_W-1:0];
        hi_fixed = base_hi + {{(BYTE_W-1){1'b0}}, wide_sum[BYTE_W]};
        pay_fix  = !read_only || wide_sum[BYTE_W];
    end
endmodule

// File: rtl/ixs_bus_drive.sv
module ixs_bus_drive
    import ixs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  seq_st_e           st,
    input  logic              is_rmw,
    input  logic [BYTE_W-1:0] zp_ptr,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi_raw,
    input  logic [BYTE_W-1:0] hi_fix,
    input  logic [BYTE_W-1:0] held_data,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic [2:0]        cyc_type,
    output logic              done
);
    localparam logic [BYTE_W-1:0] ZERO_B = '0;
    localparam logic [BYTE_W-1:0] ONE_B  = {{(BYTE_W-1){1'b0}}, 1'b1};

    always_comb begin
        bus_valid = 1'b1;
        bus_we    = 1'b0;
        bus_wdata = '0;
        done      = 1'b0;
        bus_addr  = {hi_fix, lo};
        cyc_type  = CT_NONE;
        unique case (st)
            ST_IDLE: begin
                bus_valid = 1'b0;
                bus_addr  = '0;
            end
            ST_PLO: begin
                bus_addr = {ZERO_B, zp_ptr};
                cyc_type = CT_PTR;
            end
            ST_PHI: begin
                bus_addr = {ZERO_B, zp_ptr + ONE_B};
                cyc_type = CT_PTR;
            end
            ST_FIX: begin
                bus_addr = {hi_raw, lo};
                cyc_type = CT_FIX;
            end
            ST_RD: begin
                cyc_type = CT_READ;
                done     = !is_rmw;
            end
            ST_DWR: begin
                cyc_type  = CT_DUMMY;
                bus_we    = 1'b1;
                bus_wdata = held_data;
            end
            ST_WR: begin
                cyc_type  = CT_WRITE;
                bus_we    = 1'b1;
                bus_wdata = wr_data;
                done      = 1'b1;
            end
            default: begin
                bus_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ixs_seq.sv
module ixs_seq
    import ixs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        op,
    input  logic [BYTE_W-1:0] x_idx,
    input  logic [BYTE_W-1:0] y_idx,
    input  logic [BYTE_W-1:0] oper_lo,
    input  logic [BYTE_W-1:0] oper_hi,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              done,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic [2:0]        cyc_type
);
    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        op;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] zp;
        logic [BYTE_W-1:0] ptr_lo;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi_raw;
        logic [BYTE_W-1:0] hi_fix;
        logic [BYTE_W-1:0] data;
    } seq_s;

    seq_s s_d, s_q;

    logic [BYTE_W-1:0] c_lo, c_hi, c_idx, c_sum, c_hifix;
    logic              c_rdonly, c_pay;
    logic [1:0]        c_op;

    function automatic logic is_read_op(input logic [1:0] o);
        return (o != OP_WRITE) && (o != OP_RMW);
    endfunction

    ixs_addr_calc #(.BYTE_W(BYTE_W)) u_calc (
        .base_lo  (c_lo),
        .base_hi  (c_hi),
        .index    (c_idx),
        .read_only(c_rdonly),
        .sum_lo   (c_sum),
        .hi_fixed (c_hifix),
        .pay_fix  (c_pay)
    );

    // Adder operands: request inputs when idle, fetched pointer once the
    // second pointer byte is on rd_data.
    always_comb begin
        if (s_q.st == ST_PHI) begin
            c_lo  = s_q.ptr_lo;
            c_hi  = rd_data;
            c_idx = s_q.idx;
            c_op  = s_q.op;
        end else begin
            c_lo  = oper_lo;
            c_hi  = oper_hi;
            c_idx = (mode == MODE_ABSY || mode == MODE_ZPY) ? y_idx : x_idx;
            c_op  = op;
        end
        c_rdonly = is_read_op(c_op);
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.op  = op;
                    s_d.idx = c_idx;
                    if (mode == MODE_ZPY) begin
                        s_d.zp = oper_lo;
                        s_d.st = ST_PLO;
                    end else begin
                        s_d.lo     = c_sum;
                        s_d.hi_raw = oper_hi;
                        s_d.hi_fix = c_hifix;
                        s_d.st     = c_pay ? ST_FIX : ST_RD;
                    end
                end
            end
            ST_PLO: begin
                s_d.ptr_lo = rd_data;
                s_d.st     = ST_PHI;
            end
            ST_PHI: begin
                s_d.lo     = c_sum;
                s_d.hi_raw = rd_data;
                s_d.hi_fix = c_hifix;
                s_d.st     = c_pay ? ST_FIX : ST_RD;
            end
            ST_FIX: begin
                s_d.st = (s_q.op == OP_WRITE) ? ST_WR : ST_RD;
            end
            ST_RD: begin
                if (s_q.op == OP_RMW) begin
                    s_d.data = rd_data;
                    s_d.st   = ST_DWR;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_DWR:  s_d.st = ST_WR;
            ST_WR:   s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    ixs_bus_drive #(.BYTE_W(BYTE_W)) u_drive (
        .st       (s_q.st),
        .is_rmw   (s_q.op == OP_RMW),
        .zp_ptr   (s_q.zp),
        .lo       (s_q.lo),
        .hi_raw   (s_q.hi_raw),
        .hi_fix   (s_q.hi_fix),
        .held_data(s_q.data),
        .wr_data  (wr_data),
        .bus_valid(bus_valid),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .cyc_type (cyc_type),
        .done     (done)
    );

    // R3: the cycle after a penalty keeps the low address byte
    a_r3_fix_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CT_FIX) |=> (bus_addr[BYTE_W-1:0] == $past(bus_addr[BYTE_W-1:0])));

    // R5: a plain write is always preceded by a penalty cycle
    a_r5_write_after_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CT_WRITE && s_q.op == OP_WRITE) |-> ($past(cyc_type) == CT_FIX));

    // R6: dummy write is followed by the real write at the same address
    a_r6_dummy_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CT_DUMMY) |=> (cyc_type == CT_WRITE && bus_addr == $past(bus_addr)));

    // R7: pointer reads stay in page zero
    a_r7_ptr_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CT_PTR) |-> (bus_addr[ADDR_W-1:BYTE_W] == '0 && !bus_we));

    // R8: the cycle after done is idle
    a_r8_done_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_valid);

endmodule

// File: tb/ixs_seq_bench.sv
module ixs_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0, op = '0;
    logic [7:0]  x_idx = '0, y_idx = '0, oper_lo = '0, oper_hi = '0, wr_data = '0;
    logic [7:0]  rd_data;
    logic        done, bus_valid, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [2:0]  cyc_type;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign rd_data = memf(bus_addr);

    ixs_seq u_ixs_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op(op),
        .x_idx(x_idx), .y_idx(y_idx), .oper_lo(oper_lo), .oper_hi(oper_hi),
        .rd_data(rd_data), .wr_data(wr_data), .done(done), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .cyc_type(cyc_type)
    );

    logic [2:0]  e_t [8];
    logic [15:0] e_a [8];
    logic [7:0]  e_d [8];
    int          e_n;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] t, input logic [15:0] a, input logic [7:0] d);
        e_t[e_n] = t; e_a[e_n] = a; e_d[e_n] = d; e_n++;
    endtask

    task automatic build_exp(input logic [1:0] m, input logic [1:0] o, input logic [7:0] x,
                             input logic [7:0] y, input logic [7:0] lo, input logic [7:0] hi,
                             input logic [7:0] wd);
        logic [7:0]  blo, bhi, ix;
        logic [8:0]  s;
        logic [15:0] eff;
        logic        rdo;
        e_n = 0;
        if (m == 2'd2) begin
            push(3'd1, {8'h00, lo}, 8'h00);
            push(3'd1, {8'h00, lo + 8'd1}, 8'h00);
            blo = memf({8'h00, lo});
            bhi = memf({8'h00, lo + 8'd1});
            ix  = y;
        end else begin
            blo = lo; bhi = hi;
            ix  = (m == 2'd1) ? y : x;
        end
        s   = {1'b0, blo} + {1'b0, ix};
        rdo = (o != 2'd1) && (o != 2'd2);
        if (!rdo || s[8]) push(3'd2, {bhi, s[7:0]}, 8'h00);
        eff = {bhi + {7'd0, s[8]}, s[7:0]};
        if (o == 2'd1) begin
            push(3'd4, eff, wd);
        end else begin
            push(3'd3, eff, 8'h00);
            if (o == 2'd2) begin
                push(3'd5, eff, memf(eff));
                push(3'd4, eff, wd);
            end
        end
    endtask

    function automatic string tag_of(input logic [2:0] t);
        case (t)
            3'd1: return "R7 pointer cycle";
            3'd2: return "R3 penalty cycle";
            3'd3: return "R2/R4 read cycle";
            3'd4: return "R5 write cycle";
            default: return "R6 dummy write";
        endcase
    endfunction

    // Called at a negedge with the block idle.
    task automatic run_op(input logic [1:0] m, input logic [1:0] o, input logic [7:0] x,
                          input logic [7:0] y, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] wd, input bit stray);
        build_exp(m, o, x, y, lo, hi, wd);
        mode = m; op = o; x_idx = x; y_idx = y; oper_lo = lo; oper_hi = hi; wr_data = wd;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < e_n; i++) begin
            if (stray && i == 0) begin
                start = 1'b1; mode = ~m; op = ~o; x_idx = ~x; y_idx = ~y; oper_lo = ~lo; oper_hi = ~hi;
            end else if (stray && i == 1) begin
                start = 1'b0;
            end
            chk(bus_valid && cyc_type == e_t[i] && bus_addr == e_a[i], tag_of(e_t[i]),
                {13'd0, cyc_type, bus_addr}, {13'd0, e_t[i], e_a[i]});
            chk(bus_we == (e_t[i] >= 3'd4) && (bus_we ? bus_wdata == e_d[i] : 1'b1),
                (e_t[i] == 3'd5) ? "R6 dummy data" : "R5 write flag/data",
                {23'd0, bus_we, bus_wdata}, {23'd0, e_t[i] >= 3'd4, e_d[i]});
            chk(done == (i == e_n - 1), "R8 done timing", {31'd0, done}, {31'd0, i == e_n - 1});
            @(posedge clk); @(negedge clk);
        end
        start = 1'b0;
        chk(!bus_valid && !done && cyc_type == 3'd0, "R8 idle after op (stray start ignored)",
            {28'd0, bus_valid, cyc_type}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!bus_valid && !bus_we && !done && cyc_type == 3'd0, "R1 reset state",
            {27'd0, bus_valid, bus_we, done, cyc_type[1:0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_valid && !done && cyc_type == 3'd0, "R1 idle after reset",
            {29'd0, cyc_type}, 32'd0);
        // R2 abs+X read, no carry
        run_op(2'd0, 2'd0, 8'h05, 8'hEE, 8'h10, 8'h34, 8'h00, 1'b0);
        // R3 abs+X read with carry, high byte wraps
        run_op(2'd0, 2'd0, 8'h20, 8'h00, 8'hF0, 8'hFF, 8'h00, 1'b0);
        // R4 abs+Y read with carry, mode 3 as abs+X
        run_op(2'd1, 2'd0, 8'h01, 8'h80, 8'h90, 8'h12, 8'h00, 1'b0);
        run_op(2'd3, 2'd3, 8'h02, 8'hFF, 8'h40, 8'h56, 8'h00, 1'b0);
        // R5 write without carry still pays penalty
        run_op(2'd0, 2'd1, 8'h01, 8'h00, 8'h00, 8'h20, 8'hA5, 1'b0);
        // R6 rmw, with and without carry
        run_op(2'd1, 2'd2, 8'h00, 8'h03, 8'h10, 8'h22, 8'h3C, 1'b0);
        run_op(2'd0, 2'd2, 8'hFF, 8'h00, 8'h01, 8'h7F, 8'hC3, 1'b0);
        // R7 pointer at top of page zero wraps
        run_op(2'd2, 2'd0, 8'h00, 8'h04, 8'hFF, 8'h99, 8'h00, 1'b0);
        run_op(2'd2, 2'd2, 8'h00, 8'hFF, 8'h80, 8'h00, 8'h77, 1'b0);
        // R8 stray start while busy
        run_op(2'd0, 2'd0, 8'h01, 8'h00, 8'h02, 8'h03, 8'h00, 1'b1);
        run_op(2'd2, 2'd1, 8'h00, 8'h10, 8'h44, 8'h00, 8'h12, 1'b1);
        for (int k = 0; k < 400; k++) begin
            run_op(2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom), 8'($urandom), ($urandom % 8) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule